// File: doc/BRIEF.md
# Configurable Pin Input Filter

This block conditions one asynchronous pad level before logic clocked by the system clock uses it. A 3-bit type code picks how the level enters the clock domain. It can pass straight through, with no flops in the path. It can go through a two-flop synchronizer. Or it can go through a run-length glitch filter, which changes its output only after a chosen number of consecutive samples of the synchronized level agree. That number is 2, 3, 4 or 5.

The filter does not sample on every cycle. A 3-bit select chooses its sample strobe from a small set of tick sources. Source 0 is a constant tick that samples on every system clock cycle. Sources 1 to 7 come from external clock dividers, supplied as the `tickIn` vector. An invert bit flips the conditioned level as the last step, after filtering, so the filter always judges the true pad level.

Top module: `pin_input_filter`

## Requirements
- R1: With `fltType` = 0, `condOut` equals `padIn` (XOR `invert`) as it was two system clock edges earlier, through a two-stage synchronizer.
- R2: With `fltType` = 1, `condOut` follows `padIn` XOR `invert` combinationally, in the same cycle, with no clock edge needed.
- R3: In the filter modes (`fltType` 2 to 5), the filtered level changes only at a clock edge where the selected tick source is high. With no tick, the output holds however long the pad stays changed.
- R4: In a filter mode with code N (2 to 5), the filtered level takes a new value only once the last N samples of the synchronized level all equal that value. A pad excursion that lasts fewer than N samples leaves the output unchanged.
- R5: `fltClkSel` = 0 selects a tick on every system clock cycle. `fltClkSel` = k (1 to 7) selects `tickIn[k-1]`. Ticks on sources that are not selected have no effect.
- R6: `invert` = 1 inverts `condOut` after the filter, so the filter decides on the true pad level.
- R7: Reset (`rst`, synchronous, active high) clears the synchronizer, the sample history and the filtered level to 0. In the synchronized and filter modes, `condOut` then equals `invert`.
- R8: Type codes 6 and 7 behave exactly as code 0, with a two-edge synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| padIn | input | 1 | Raw asynchronous pad level |
| fltType | input | 3 | Conditioning type: 0 sync, 1 direct, 2-5 filter depth, 6-7 as 0 |
| fltClkSel | input | 3 | Filter sample tick source: 0 every cycle, k = tickIn[k-1] |
| invert | input | 1 | Invert the conditioned level |
| tickIn | input | 7 | Divider tick strobes for sources 1 to 7 |
| condOut | output | 1 | Conditioned pad level |

## Verification
The sync mode and the spare codes 6 and 7 get a single clean step, checked one edge before and one edge after the expected arrival. This separates a two-flop path from one flop, from three flops and from a direct path. Each filter depth gets a pulse one sample shorter than its depth, followed by a held level checked on the edge before and the edge of the change. Together these show whether the agreement count is exactly N. Tick selection is driven by hand-placed pulses on the chosen source and on a source that is not selected. This tells a filter paced by the right strobe from one that counts every cycle or listens to the wrong source. An inverted run shows that inversion comes after the filter.

// File: rtl/pinflt_pkg.sv
package pinflt_pkg;
  localparam int PF_TYPE_W    = 3;
  localparam int PF_SEL_W     = 3;
  localparam int PF_MAX_DEPTH = 5;
  localparam int PF_DEPTH_W   = $clog2(PF_MAX_DEPTH + 1);
  localparam int PF_NUM_DIV   = (1 << PF_SEL_W) - 1;

  typedef enum logic [PF_TYPE_W-1:0] {
    FT_SYNC   = 3'd0,
    FT_DIRECT = 3'd1,
    FT_RUN2   = 3'd2,
    FT_RUN3   = 3'd3,
    FT_RUN4   = 3'd4,
    FT_RUN5   = 3'd5
  } pinflt_type_e;

  typedef struct packed {
    logic                  sampleEn;
    logic                  useDirect;
    logic                  useFilter;
    logic [PF_DEPTH_W-1:0] depth;
  } pinflt_ctl_t;
endpackage

// File: rtl/pinflt_sync.sv
module pinflt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinflt_ctrl.sv
module pinflt_ctrl
  import pinflt_pkg::*;
#(
  parameter int TYPE_W    = PF_TYPE_W,
  parameter int SEL_W     = PF_SEL_W,
  parameter int NUM_DIV   = PF_NUM_DIV,
  parameter int MAX_DEPTH = PF_MAX_DEPTH
) (
  input  logic [TYPE_W-1:0]  fltType,
  input  logic [SEL_W-1:0]   fltClkSel,
  input  logic [NUM_DIV-1:0] tickIn,
  output pinflt_ctl_t        ctl
);
  localparam int NUM_SRC = NUM_DIV + 1;

  logic [NUM_SRC-1:0] tickSrc;
  logic               selTick;

  // source 0 is the always-on tick
  assign tickSrc = {tickIn, 1'b1};

  always_comb begin
    selTick = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (fltClkSel == SEL_W'(k)) selTick = tickSrc[k];
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.sampleEn  = selTick;
    if (fltType == TYPE_W'(FT_DIRECT)) begin
      ctl.useDirect = 1'b1;
    end else if (fltType >= TYPE_W'(2) && fltType <= TYPE_W'(MAX_DEPTH)) begin
      ctl.useFilter = 1'b1;
      ctl.depth     = PF_DEPTH_W'(fltType);
    end
  end
endmodule

// File: rtl/pinflt_datapath.sv
module pinflt_datapath
  import pinflt_pkg::*;
#(
  parameter int MAX_DEPTH   = PF_MAX_DEPTH,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        padIn,
  input  logic        invert,
  input  pinflt_ctl_t ctl,
  output logic        syncLvl,
  output logic        filtLvl,
  output logic        condOut
);
  localparam int HIST_W = MAX_DEPTH - 1;

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] agree;
  logic              allAgree;
  logic              selLvl;

  pinflt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(padIn), .q(syncLvl)
  );

  // sample history, newest in bit 0
  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (rst)               hist <= '0;
        else if (ctl.sampleEn) hist <= syncLvl;
      end
    end else begin : g_histN
      always_ff @(posedge clk) begin
        if (rst)               hist <= '0;
        else if (ctl.sampleEn) hist <= {hist[HIST_W-2:0], syncLvl};
      end
    end
  endgenerate

  // older sample i matters only when depth exceeds i+1
  generate
    for (genvar i = 0; i < HIST_W; i++) begin : g_agree
      localparam logic [PF_DEPTH_W-1:0] POS = PF_DEPTH_W'(i + 1);
      assign agree[i] = (hist[i] == syncLvl) || (ctl.depth <= POS);
    end
  endgenerate

  assign allAgree = &agree;

  always_ff @(posedge clk) begin
    if (rst)
      filtLvl <= 1'b0;
    else if (ctl.useFilter && ctl.sampleEn && allAgree)
      filtLvl <= syncLvl;
  end

  always_comb begin
    if (ctl.useDirect)      selLvl = padIn;
    else if (ctl.useFilter) selLvl = filtLvl;
    else                    selLvl = syncLvl;
  end

  assign condOut = selLvl ^ invert;
endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter
  import pinflt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  padIn,
  input  logic [PF_TYPE_W-1:0]  fltType,
  input  logic [PF_SEL_W-1:0]   fltClkSel,
  input  logic                  invert,
  input  logic [PF_NUM_DIV-1:0] tickIn,
  output logic                  condOut
);
  pinflt_ctl_t ctl;
  logic        syncLvl;
  logic        filtLvl;

  pinflt_ctrl u_ctrl (
    .fltType(fltType), .fltClkSel(fltClkSel), .tickIn(tickIn), .ctl(ctl)
  );

  pinflt_datapath u_dp (
    .clk(clk), .rst(rst), .padIn(padIn), .invert(invert), .ctl(ctl),
    .syncLvl(syncLvl), .filtLvl(filtLvl), .condOut(condOut)
  );
endmodule

// File: rtl/pinflt_checker.sv
module pinflt_checker
  import pinflt_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  padIn,
  input logic [PF_TYPE_W-1:0]  fltType,
  input logic [PF_SEL_W-1:0]   fltClkSel,
  input logic                  invert,
  input logic [PF_NUM_DIV-1:0] tickIn,
  input logic                  condOut,
  input logic                  syncLvl,
  input logic                  filtLvl
);
  logic [1:0]            sinceRst;
  logic                  inFilter;
  logic                  inSync;
  logic [PF_NUM_DIV:0]   srcVec;
  logic                  selTick;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 3) sinceRst <= sinceRst + 2'd1;
  end

  assign inFilter = (fltType >= 3'd2) && (fltType <= 3'd5);
  assign inSync   = !inFilter && (fltType != 3'd1);
  assign srcVec   = {tickIn, 1'b1};
  assign selTick  = srcVec[fltClkSel];

  // R1 / R8: synchronized path lags the pad by two edges
  a_r1_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (inSync && sinceRst >= 2) |-> ((condOut ^ invert) == $past(padIn, 2)));

  // R3: filtered level moves only after a selected tick in filter mode
  a_r3_move_on_tick: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 1 && filtLvl != $past(filtLvl)) |-> ($past(selTick) && $past(inFilter)));

  // R4: a new filtered level is always the sampled synchronized level
  a_r4_takes_sample: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 1 && filtLvl != $past(filtLvl)) |-> (filtLvl == $past(syncLvl)));

  // R7: leaving reset, all state is zero
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (filtLvl == 1'b0 && syncLvl == 1'b0));
endmodule

bind pin_input_filter pinflt_checker u_chk (
  .clk(clk), .rst(rst), .padIn(padIn), .fltType(fltType),
  .fltClkSel(fltClkSel), .invert(invert), .tickIn(tickIn),
  .condOut(condOut), .syncLvl(syncLvl), .filtLvl(filtLvl)
);

// File: tb/test_pin_input_filter.sv
`timescale 1ns/1ps
module test_pin_input_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       padIn = 1'b0;
  logic [2:0] fltType = 3'd0;
  logic [2:0] fltClkSel = 3'd0;
  logic       invert = 1'b0;
  logic [6:0] tickIn = '0;
  logic       condOut;
  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_input_filter i_pin_input_filter (
    .clk(clk), .rst(rst), .padIn(padIn), .fltType(fltType),
    .fltClkSel(fltClkSel), .invert(invert), .tickIn(tickIn), .condOut(condOut)
  );

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input logic exp, input string tag);
    nVec++;
    if (condOut !== exp) begin
      nBad++;
      $display("FAIL %s: condOut=%b expected=%b", tag, condOut, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    padIn = 1'b1; fltType = 3'd0; invert = 1'b0;
    rst = 1'b1; cyc(3);
    check(1'b0, "R7 sync mode in reset");
    fltType = 3'd3; #1;
    check(1'b0, "R7 filter mode in reset");
    invert = 1'b1; #1;
    check(1'b1, "R7 inverted in reset");
    invert = 1'b0; padIn = 1'b0; fltType = 3'd0;
    rst = 1'b0; cyc(1);
    check(1'b0, "R7 first cycle after reset");
  endtask

  task automatic t_sync(input logic [2:0] code, input string tag);
    doReset();
    fltType = code; invert = 1'b0; padIn = 1'b0;
    cyc(4);
    padIn = 1'b1;
    cyc(1); check(1'b0, {tag, " rise one edge"});
    cyc(1); check(1'b1, {tag, " rise two edges"});
    padIn = 1'b0;
    cyc(1); check(1'b1, {tag, " fall one edge"});
    cyc(1); check(1'b0, {tag, " fall two edges"});
  endtask

  task automatic t_direct();
    fltType = 3'd1; invert = 1'b0;
    padIn = 1'b1; #1; check(1'b1, "R2 direct high, no edge");
    padIn = 1'b0; #1; check(1'b0, "R2 direct low, no edge");
    invert = 1'b1; #1; check(1'b1, "R6 direct inverted");
    invert = 1'b0; #1;
  endtask

  task automatic t_filter(input int depth);
    doReset();
    fltType = 3'(depth); fltClkSel = 3'd0; invert = 1'b0; padIn = 1'b0;
    cyc(8);
    // excursion of depth-1 samples
    padIn = 1'b1; cyc(depth - 1); padIn = 1'b0;
    cyc(10);
    check(1'b0, $sformatf("R4 depth %0d short pulse rejected", depth));
    padIn = 1'b1;
    cyc(depth + 1); check(1'b0, $sformatf("R4 depth %0d rise edge before", depth));
    cyc(1);         check(1'b1, $sformatf("R4 depth %0d rise accepted", depth));
    padIn = 1'b0;
    cyc(depth + 1); check(1'b1, $sformatf("R4 depth %0d fall edge before", depth));
    cyc(1);         check(1'b0, $sformatf("R4 depth %0d fall accepted", depth));
  endtask

  task automatic pulseTick(input int bitIdx);
    tickIn = '0; tickIn[bitIdx] = 1'b1;
    cyc(1);
    tickIn = '0;
    cyc(1);
  endtask

  task automatic t_clksel();
    doReset();
    fltType = 3'd2; fltClkSel = 3'd2; invert = 1'b0; tickIn = '0; padIn = 1'b1;
    cyc(10);
    check(1'b0, "R3 no tick, output held");
    pulseTick(0); pulseTick(0); pulseTick(2);
    check(1'b0, "R5 unselected sources ignored");
    pulseTick(1);
    check(1'b0, "R5 one selected tick not enough");
    tickIn[1] = 1'b1; cyc(1); tickIn = '0;
    check(1'b1, "R5 second selected tick accepted");
    fltClkSel = 3'd7; padIn = 1'b0;
    cyc(6);
    check(1'b1, "R3 sel 7 no tick, held");
    pulseTick(6); pulseTick(6);
    check(1'b0, "R5 sel 7 uses tickIn[6]");
    fltClkSel = 3'd0;
  endtask

  task automatic t_invert();
    doReset();
    fltType = 3'd3; fltClkSel = 3'd0; invert = 1'b1; padIn = 1'b0;
    #1; check(1'b1, "R6 inverted after reset");
    padIn = 1'b1;
    cyc(4); check(1'b1, "R6 filter not yet changed");
    cyc(1); check(1'b0, "R6 filtered true level then inverted");
    invert = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sync(3'd0, "R1 type 0");
    t_sync(3'd6, "R8 type 6");
    t_sync(3'd7, "R8 type 7");
    t_direct();
    for (int d = 2; d <= 5; d++) t_filter(d);
    t_clksel();
    t_invert();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule